// File: doc/BRIEF.md
# Reversible Register Update Unit

This unit works out the next value of one destination register for a single 16-bit instruction. The instruction can run forward or in reverse. A caller supplies an operation select, a direction flag, the current destination value, a 16-bit source operand, an 8-bit immediate and, for reverse steps, a word popped from an undo stack. One clock later the unit returns the new destination value together with its side-effect requests.

Operations that can be inverted are undone by applying their algebraic inverse. Operations that overwrite information save the old destination value instead. In forward direction they raise a push request and present the old value. In reverse direction they raise a pop request and take the supplied popped word as the restored value. The exchange operation returns the memory word as the new destination value and hands the old destination value back for writing to memory. It does this the same way in both directions.

Decoding, the undo stack storage, memory addressing and program-counter control are handled by neighbouring logic.

Top module: `rev_reg_update`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `push_req`, `pop_req`, `mem_we`, `d_out`, `push_data` and `mem_wdata` are all zero.
- R2: Op 0 (high-byte xor) yields `d_in ^ {imm,8'h00}` and op 1 (low-byte xor) yields `d_in ^ {8'h00,imm}`, with the same result in either direction and no push, pop or memory write.
- R3: Op 4 yields `d_in+src` forward and `d_in-src` reverse. Op 5 yields `d_in-src` forward and `d_in+src` reverse. Op 6 yields `d_in^src` in both directions. None of them raises a flag. Applying forward and then reverse with the same operands returns the original value.
- R4: Op 8 rotates `d_in` left by `src[3:0]` forward and right by `src[3:0]` in reverse. The upper source bits are ignored and no flag is raised.
- R5: In forward direction the state-losing ops give these results. Op 2 gives `{imm,8'h00}`. Op 3 gives `imm` sign-extended. Op 9 gives `d_in` arithmetically shifted right by `src[3:0]`. Op 10 gives `d_in|src`. Op 11 gives `d_in&src`. Op 12 gives `src`. In reverse direction each of them yields `pop_data`.
- R6: `push_req` is high only for a forward state-losing op, and `push_data` then equals that step's `d_in`. `pop_req` is high only for a reverse state-losing op. The two are never high together.
- R7: A step presented with `in_valid` high shows its results one cycle later with `out_valid` high. On a cycle after `in_valid` was low, `out_valid`, `push_req`, `pop_req` and `mem_we` are all low.
- R8: Op 7 (exchange) yields `src` as the new destination value. It raises `mem_we` with `mem_wdata` equal to `d_in`, identically in both directions, and raises no push or pop.
- R9: Op codes 13 to 15 are unused: the result equals `d_in` and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A step is presented this cycle |
| op | input | 4 | Operation select (codes in R2 to R9) |
| reverse | input | 1 | 1 = undo the operation |
| d_in | input | 16 | Current destination register value |
| src | input | 16 | Source operand (memory word for exchange) |
| imm | input | 8 | 8-bit immediate |
| pop_data | input | 16 | Word popped from the undo stack |
| out_valid | output | 1 | Results of the previous step are valid |
| d_out | output | 16 | New destination register value |
| push_req | output | 1 | Push `push_data` onto the undo stack |
| push_data | output | 16 | Old destination value to save |
| pop_req | output | 1 | One word was consumed from the undo stack |
| mem_we | output | 1 | Write `mem_wdata` to the exchanged memory word |
| mem_wdata | output | 16 | Old destination value for the exchange |

## Verification
The bench aims at rotate and shift amounts of 0 and 15 and at source words whose upper bits are set. A design that used the full source word as the amount, or mixed up rotation and shift, would return a wrong value there. It also runs forward-then-reverse chains through a real undo queue. Swapped add and subtract inverses, a missing push or a stale popped word would leave the register different from its starting value. Idle gaps between steps expose flags that stay high for more than one cycle, and the unused codes expose a decoder that falls through to a real operation.

// File: rtl/rev_reg_update.sv
module rev_reg_update #(
  parameter int W  = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic          reverse,
  input  logic [W-1:0]  d_in,
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] imm,
  input  logic [W-1:0]  pop_data,
  output logic          out_valid,
  output logic [W-1:0]  d_out,
  output logic          push_req,
  output logic [W-1:0]  push_data,
  output logic          pop_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata
);
  localparam int SHW = $clog2(W);
  localparam logic [3:0] OP_XHI = 4'd0, OP_XLO = 4'd1, OP_LHI = 4'd2, OP_LLO = 4'd3,
                         OP_ADD = 4'd4, OP_SUB = 4'd5, OP_XOR = 4'd6, OP_EX  = 4'd7,
                         OP_ROL = 4'd8, OP_SHR = 4'd9, OP_OR  = 4'd10, OP_AND = 4'd11,
                         OP_DUP = 4'd12;

  logic [SHW-1:0] amt;
  logic [2*W-1:0] dd, rl, rr;
  logic [W-1:0]   hi_imm, lo_imm, sx_imm, fwd_val, nxt;
  logic           lossy;

  assign amt    = src[SHW-1:0];
  assign dd     = {d_in, d_in};
  assign rl     = dd << amt;
  assign rr     = dd >> amt;
  assign hi_imm = {imm, {(W-IW){1'b0}}};
  assign lo_imm = {{(W-IW){1'b0}}, imm};
  assign sx_imm = {{(W-IW){imm[IW-1]}}, imm};
  assign lossy  = (op == OP_LHI) || (op == OP_LLO) || (op == OP_SHR) ||
                  (op == OP_OR)  || (op == OP_AND) || (op == OP_DUP);

  always_comb begin
    case (op)
      OP_LHI:  fwd_val = hi_imm;
      OP_LLO:  fwd_val = sx_imm;
      OP_SHR:  fwd_val = W'($signed(d_in) >>> amt);
      OP_OR:   fwd_val = d_in | src;
      OP_AND:  fwd_val = d_in & src;
      OP_DUP:  fwd_val = src;
      default: fwd_val = d_in;
    endcase
  end

  always_comb begin
    case (op)
      OP_XHI:  nxt = d_in ^ hi_imm;
      OP_XLO:  nxt = d_in ^ lo_imm;
      OP_ADD:  nxt = reverse ? d_in - src : d_in + src;
      OP_SUB:  nxt = reverse ? d_in + src : d_in - src;
      OP_XOR:  nxt = d_in ^ src;
      OP_EX:   nxt = src;
      OP_ROL:  nxt = reverse ? rr[W-1:0] : rl[2*W-1:W];
      default: nxt = (lossy && reverse) ? pop_data : fwd_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      push_req  <= 1'b0;
      pop_req   <= 1'b0;
      mem_we    <= 1'b0;
      d_out     <= '0;
      push_data <= '0;
      mem_wdata <= '0;
    end else begin
      out_valid <= in_valid;
      push_req  <= in_valid && lossy && !reverse;
      pop_req   <= in_valid && lossy && reverse;
      mem_we    <= in_valid && (op == OP_EX);
      if (in_valid) begin
        d_out     <= nxt;
        push_data <= d_in;
        mem_wdata <= d_in;
      end
    end
  end

  p_no_push_and_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req && pop_req));
  p_push_holds_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !reverse && lossy |=> push_req && push_data == $past(d_in));
  p_pop_restores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && reverse && lossy |=> pop_req && d_out == $past(pop_data));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !push_req && !pop_req && !mem_we);
  p_flags_need_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req || pop_req || mem_we) |-> out_valid);
  p_swap_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_EX |=> mem_we && mem_wdata == $past(d_in) && d_out == $past(src));
endmodule

// File: tb/test_rev_reg_update.sv
module test_rev_reg_update;
  logic clk = 0, rst_n = 0, in_valid = 0, reverse = 0;
  logic [3:0] op = 0;
  logic [15:0] d_in = 0, src = 0, pop_data = 0;
  logic [7:0] imm = 0;
  logic out_valid, push_req, pop_req, mem_we;
  logic [15:0] d_out, push_data, mem_wdata;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rev_reg_update i_rev_reg_update (.clk, .rst_n, .in_valid, .op, .reverse, .d_in, .src,
    .imm, .pop_data, .out_valid, .d_out, .push_req, .push_data, .pop_req, .mem_we, .mem_wdata);

  function automatic bit is_lossy(input logic [3:0] o);
    return o == 2 || o == 3 || o == 9 || o == 10 || o == 11 || o == 12;
  endfunction

  function automatic string tag(input logic [3:0] o);
    if (o <= 1) return "R2";
    if (o >= 4 && o <= 6) return "R3";
    if (o == 7) return "R8";
    if (o == 8) return "R4";
    if (o >= 13) return "R9";
    return "R5";
  endfunction

  function automatic logic [15:0] model(input logic [3:0] o, input logic rv,
      input logic [15:0] d, s, input logic [7:0] im, input logic [15:0] pd);
    logic [15:0] x;
    int n;
    x = d;
    n = s % 16;
    case (o)
      0: x = d ^ (16'(im) * 256);
      1: x = d ^ 16'(im);
      4: x = rv ? d - s : d + s;
      5: x = rv ? d + s : d - s;
      6: x = d ^ s;
      7: x = s;
      8: for (int k = 0; k < n; k++) x = rv ? {x[0], x[15:1]} : {x[14:0], x[15]};
      default: ;
    endcase
    if (is_lossy(o)) begin
      if (rv) x = pd;
      else case (o)
        2: x = 16'(im) * 256;
        3: x = im[7] ? 16'hff00 | 16'(im) : 16'(im);
        9: for (int k = 0; k < n; k++) x = {x[15], x[15:1]};
        10: x = d | s;
        11: x = d & s;
        default: x = s;
      endcase
    end
    return x;
  endfunction

  logic e_v = 0, e_pu = 0, e_po = 0, e_we = 0;
  logic [15:0] e_d = 0, e_old = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v = 0; e_pu = 0; e_po = 0; e_we = 0; e_d = 0; e_old = 0; e_tag = "R1";
    end else begin
      e_v = in_valid;
      e_pu = in_valid && is_lossy(op) && !reverse;
      e_po = in_valid && is_lossy(op) && reverse;
      e_we = in_valid && op == 7;
      if (in_valid) begin
        e_d = model(op, reverse, d_in, src, imm, pop_data);
        e_old = d_in;
        e_tag = tag(op);
      end else e_tag = "R7";
    end
  end

  task automatic chk(input string r, input string what, input logic [15:0] act, exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(e_tag, "out_valid", 16'(out_valid), 16'(e_v));
    chk("R6", "push_req", 16'(push_req), 16'(e_pu));
    chk("R6", "pop_req", 16'(pop_req), 16'(e_po));
    chk("R8", "mem_we", 16'(mem_we), 16'(e_we));
    if (e_v) begin
      chk(e_tag, "d_out", d_out, e_d);
      if (e_pu) chk("R6", "push_data", push_data, e_old);
      if (e_we) chk("R8", "mem_wdata", mem_wdata, e_old);
    end
  end

  task automatic step(input logic [3:0] o, input logic rv, input logic [15:0] d, s,
      input logic [7:0] im, input logic [15:0] pd, output logic [15:0] res);
    @(negedge clk);
    in_valid = 1; op = o; reverse = rv; d_in = d; src = s; imm = im; pop_data = pd;
    @(posedge clk); #1;
    res = d_out;
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] r, start;
    logic [15:0] undo[$];
    logic [3:0] ops[$];
    logic [15:0] srcs[$];
    logic [7:0] imms[$];
    repeat (3) @(negedge clk);
    chk("R1", "reset d_out", d_out, 0);
    chk("R1", "reset out_valid", 16'(out_valid), 0);
    chk("R1", "reset push_data", push_data, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset flags", 16'({out_valid, push_req, pop_req, mem_we}), 0);
    chk("R1", "post-reset mem_wdata", mem_wdata, 0);
    // directed corners: rotate/shift amounts 0 and 15 with upper bits set (R4, R5)
    step(8, 0, 16'h8001, 16'hfff0, 0, 0, r);
    step(8, 0, 16'h8001, 16'h000f, 0, 0, r);
    step(8, 1, 16'h8001, 16'h001f, 0, 0, r);
    step(9, 0, 16'h8000, 16'h00ff, 0, 0, r);
    step(9, 0, 16'h4000, 16'h0000, 0, 0, r);
    step(3, 0, 16'h1234, 0, 8'h80, 0, r);
    step(2, 0, 16'h1234, 0, 8'hab, 0, r);
    step(9, 1, 16'h1234, 0, 0, 16'hbeef, r);
    idle(2);
    step(7, 1, 16'h1111, 16'h2222, 0, 0, r);
    step(13, 0, 16'h5a5a, 16'hffff, 8'hff, 16'h1, r);
    step(15, 1, 16'h5a5a, 16'hffff, 8'hff, 16'h1, r);
    step(4, 0, 16'hffff, 16'h0001, 0, 0, r);
    step(5, 1, 16'hffff, 16'h0001, 0, 0, r);
    idle(1);
    // random single steps with idle gaps (all requirements)
    for (int i = 0; i < 300; i++) begin
      step(4'($urandom % 16), 1'($urandom), 16'($urandom), 16'($urandom),
           8'($urandom), 16'($urandom), r);
      if ($urandom % 4 == 0) idle($urandom % 3);
    end
    // forward/reverse round trips through an undo queue (R3, R5)
    for (int t = 0; t < 40; t++) begin
      start = 16'($urandom); r = start;
      ops.delete(); srcs.delete(); imms.delete(); undo.delete();
      for (int j = 0; j < 8; j++) begin
        logic [3:0] o;
        o = 4'($urandom % 13);
        if (o == 7) o = 6;
        ops.push_back(o); srcs.push_back(16'($urandom)); imms.push_back(8'($urandom));
        if (is_lossy(o)) undo.push_back(r);
        step(o, 0, r, srcs[j], imms[j], 0, r);
      end
      for (int j = 7; j >= 0; j--) begin
        logic [15:0] pd;
        pd = is_lossy(ops[j]) ? undo.pop_back() : 16'h0;
        step(ops[j], 1, r, srcs[j], imms[j], pd, r);
      end
      idle(1);
      chk("R5", "round trip restore", r, start);
    end
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule